// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block lets a processor operate a raw NAND flash part one byte at a time through a small register window. The processor writes a control byte that sets the command-latch, address-latch, chip-select and write-protect pins directly. The same byte also carries a two-bit command for an external ECC engine. Bytes written to a four-address data window are driven onto the flash I/O bus. Bytes read from that window are returned from the flash I/O bus in the same access.

A status byte, an event register and an enable register together produce one interrupt line toward a parent interrupt controller. Every data-window write records an event in bit 0 of the event register. The interrupt is raised only when enable bit 7 acts as a master switch and at least one enabled bit matches a pending event bit. The ECC engine and the flash device sit outside the block. The block only produces the ECC reset pulse and the ECC level selects.

Top module: `nand_host_if`

## Requirements
- R1: A write to offsets 0x00, 0x01, 0x02 or 0x03 drives `nf_io_wr` high in the same cycle as the write, with `nf_io_out` equal to the written byte.
- R2: A read of offsets 0x00 to 0x03 drives `nf_io_rd` high and returns `nf_io_in` on `reg_rdata` in the same cycle.
- R3: A write to offset 0x04 stores the control byte, which reads back at 0x04 from the next cycle. The pins follow from the next cycle: `nf_cle` = bit 0, `nf_ale` = bit 1, `nf_ce_n` = NOT bit 4, and `nf_wp` = bit 7.
- R4: Control bits 6:5 are the ECC command. 01 or 11 gives a one-cycle `ecc_rst` pulse in the cycle after the write. `ecc_en` is high while the field holds 01. `ecc_rd` is high while the field holds 10. 00 gives no pulse and both levels low.
- R5: A read of offset 0x05 returns the constant 0x14.
- R6: The event register (offset 0x06) and the enable register (offset 0x07) take the full written byte and read it back from the next cycle.
- R7: A data-window write sets event bit 0 in the next cycle and leaves the other event bits unchanged.
- R8: `sub_irq` is high exactly when enable bit 7 is 1 and (enable AND event) is nonzero.
- R9: After reset the control, event and enable registers are 0x00, so `nf_ce_n` is 1, the other pins are 0, and `sub_irq` and the ECC outputs are 0.
- R10: Writes to offsets 0x08 to 0xFF change no register, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of `reg_rd` |
| nf_cle | output | 1 | Command latch enable pin |
| nf_ale | output | 1 | Address latch enable pin |
| nf_ce_n | output | 1 | Chip enable pin, active low |
| nf_wp | output | 1 | Write-protect pin level |
| nf_io_out | output | 8 | Byte toward the flash I/O bus |
| nf_io_wr | output | 1 | Flash I/O write strobe |
| nf_io_in | input | 8 | Byte from the flash I/O bus |
| nf_io_rd | output | 1 | Flash I/O read strobe |
| ecc_rst | output | 1 | One-cycle ECC reset pulse |
| ecc_en | output | 1 | ECC calculation enable level |
| ecc_rd | output | 1 | ECC result-read select level |
| sub_irq | output | 1 | Interrupt request to the parent controller |

## Verification
On every cycle, the assertions check these rules:
- A control write sets the pins, with chip enable inverted, from the next cycle.
- An ECC reset pulse only ever follows a control write whose field is 01 or 11.
- A data write sets event bit 0.
- The interrupt is never high while the master enable bit is clear.
- The registers hold still through writes to unmapped offsets.

Only the bench's scenarios can show the rest. This covers the full readback values, the exact interrupt level for mixed event and enable patterns, and the same-cycle return of flash input bytes. It also covers the constant status byte, and that an event bit set by a data write survives until software overwrites it.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned OFF_W    = 8;
  localparam int unsigned WIN_SIZE = 4;

  localparam logic [OFF_W-1:0] OFF_CTRL  = 8'h04;
  localparam logic [OFF_W-1:0] OFF_STAT  = 8'h05;
  localparam logic [OFF_W-1:0] OFF_EVT   = 8'h06;
  localparam logic [OFF_W-1:0] OFF_ENA   = 8'h07;
  localparam logic [DATA_W-1:0] STAT_VAL = 8'h14;

  localparam int unsigned BIT_CLE  = 0;
  localparam int unsigned BIT_ALE  = 1;
  localparam int unsigned BIT_CE   = 4;
  localparam int unsigned BIT_ECC0 = 5;
  localparam int unsigned BIT_WP   = 7;
  localparam int unsigned BIT_MSTR = 7;

  typedef enum logic [1:0] {
    ECC_NOP    = 2'b00,
    ECC_EN_RST = 2'b01,
    ECC_RDSEL  = 2'b10,
    ECC_CLR    = 2'b11
  } ecc_cmd_e;

  typedef struct packed {
    logic data;
    logic ctrl;
    logic stat;
    logic evt;
    logic ena;
  } reg_hit_t;

  function automatic ecc_cmd_e ecc_field(input logic [DATA_W-1:0] ctrl);
    return ecc_cmd_e'(ctrl[BIT_ECC0+1:BIT_ECC0]);
  endfunction

  function automatic logic ecc_wants_reset(input ecc_cmd_e cmd);
    return (cmd == ECC_EN_RST) || (cmd == ECC_CLR);
  endfunction

  function automatic logic irq_level(input logic [DATA_W-1:0] evt,
                                     input logic [DATA_W-1:0] ena);
    return ena[BIT_MSTR] && ((evt & ena) != '0);
  endfunction
endpackage

// File: rtl/nand_addr_dec.sv
module nand_addr_dec
  import nand_host_pkg::*;
(
  input  logic [OFF_W-1:0] addr,
  output reg_hit_t         hit
);
  localparam int unsigned LOW_W = 3;

  logic in_page;
  assign in_page = (addr[OFF_W-1:LOW_W] == '0);

  always_comb begin
    hit      = '0;
    hit.data = in_page && (addr[LOW_W-1:0] < LOW_W'(WIN_SIZE));
    hit.ctrl = (addr == OFF_CTRL);
    hit.stat = (addr == OFF_STAT);
    hit.evt  = (addr == OFF_EVT);
    hit.ena  = (addr == OFF_ENA);
  end
endmodule

// File: rtl/nand_ctrl_reg.sv
module nand_ctrl_reg
  import nand_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              pin_cle,
  output logic              pin_ale,
  output logic              pin_ce_n,
  output logic              pin_wp,
  output logic              ecc_rst_pulse,
  output logic              ecc_en_lvl,
  output logic              ecc_rd_lvl
);
  ecc_cmd_e cmd_now;
  logic     reset_req;

  assign cmd_now   = ecc_field(wdata);
  assign reset_req = ctrl_we && ecc_wants_reset(cmd_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q        <= '0;
      ecc_rst_pulse <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= wdata;
      ecc_rst_pulse <= reset_req;
    end
  end

  assign pin_cle    = ctrl_q[BIT_CLE];
  assign pin_ale    = ctrl_q[BIT_ALE];
  assign pin_ce_n   = ~ctrl_q[BIT_CE];
  assign pin_wp     = ctrl_q[BIT_WP];
  assign ecc_en_lvl = (ecc_field(ctrl_q) == ECC_EN_RST);
  assign ecc_rd_lvl = (ecc_field(ctrl_q) == ECC_RDSEL);

  AST_CE_INVERTED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (pin_ce_n == !$past(wdata[BIT_CE]))); // R3
  AST_PINS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (pin_cle == $past(wdata[BIT_CLE]) && pin_ale == $past(wdata[BIT_ALE])
                 && pin_wp == $past(wdata[BIT_WP]))); // R3
  AST_ECC_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_rst_pulse |-> ($past(ctrl_we) && $past(wdata[BIT_ECC0]))); // R4
  AST_ECC_LEVELS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ecc_en_lvl && ecc_rd_lvl)); // R4
endmodule

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl
  import nand_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_we,
  input  logic              ena_we,
  input  logic              data_wr_evt,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] evt_q,
  output logic [DATA_W-1:0] ena_q,
  output logic              irq
);
  logic [DATA_W-1:0] evt_next;

  always_comb begin
    evt_next = evt_q;
    if (evt_we)      evt_next = wdata;
    if (data_wr_evt) evt_next[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      ena_q <= '0;
    end else begin
      evt_q <= evt_next;
      if (ena_we) ena_q <= wdata;
    end
  end

  assign irq = irq_level(evt_q, ena_q);

  AST_DATA_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt |=> evt_q[0]); // R7
  AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ena_q[BIT_MSTR]); // R8
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_we && !data_wr_evt) |=> $stable(evt_q)); // R6
endmodule

// File: rtl/nand_host_if.sv
module nand_host_if
  import nand_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_ce_n,
  output logic              nf_wp,
  output logic [DATA_W-1:0] nf_io_out,
  output logic              nf_io_wr,
  input  logic [DATA_W-1:0] nf_io_in,
  output logic              nf_io_rd,
  output logic              ecc_rst,
  output logic              ecc_en,
  output logic              ecc_rd,
  output logic              sub_irq
);
  reg_hit_t          hit;
  logic [DATA_W-1:0] ctrl_q, evt_q, ena_q;
  logic              any_hit;
  logic              unmapped_wr;

  nand_addr_dec u_dec (
    .addr (reg_addr),
    .hit  (hit)
  );

  nand_ctrl_reg u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_we       (reg_wr && hit.ctrl),
    .wdata         (reg_wdata),
    .ctrl_q        (ctrl_q),
    .pin_cle       (nf_cle),
    .pin_ale       (nf_ale),
    .pin_ce_n      (nf_ce_n),
    .pin_wp        (nf_wp),
    .ecc_rst_pulse (ecc_rst),
    .ecc_en_lvl    (ecc_en),
    .ecc_rd_lvl    (ecc_rd)
  );

  nand_irq_ctrl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_we      (reg_wr && hit.evt),
    .ena_we      (reg_wr && hit.ena),
    .data_wr_evt (nf_io_wr),
    .wdata       (reg_wdata),
    .evt_q       (evt_q),
    .ena_q       (ena_q),
    .irq         (sub_irq)
  );

  assign nf_io_wr  = reg_wr && hit.data;
  assign nf_io_rd  = reg_rd && hit.data;
  assign nf_io_out = reg_wdata;

  assign any_hit     = |hit;
  assign unmapped_wr = reg_wr && !any_hit;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (1'b1)
        hit.data: reg_rdata = nf_io_in;
        hit.ctrl: reg_rdata = ctrl_q;
        hit.stat: reg_rdata = STAT_VAL;
        hit.evt:  reg_rdata = evt_q;
        hit.ena:  reg_rdata = ena_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> ($stable(ctrl_q) && $stable(evt_q) && $stable(ena_q))); // R10
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R10
  AST_IO_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_rd) |-> !nf_io_rd); // R2
endmodule

// File: tb/nand_host_if_tb.sv
module nand_host_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, nf_io_in = '0;
  logic [7:0] reg_rdata, nf_io_out;
  logic       nf_cle, nf_ale, nf_ce_n, nf_wp, nf_io_wr, nf_io_rd;
  logic       ecc_rst, ecc_en, ecc_rd, sub_irq;

  int checks = 0, fails = 0;
  logic [7:0] m_ctrl = 0, m_evt = 0, m_ena = 0;

  always #2 clk = ~clk;

  nand_host_if u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_irq();
    return m_ena[7] && ((m_evt & m_ena) != 0);
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a, input logic [7:0] din);
    if (a < 8'h04) return din;
    case (a)
      8'h04: return m_ctrl;
      8'h05: return 8'h14;
      8'h06: return m_evt;
      8'h07: return m_ena;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_pins();
    chk("R3 cle", nf_cle, m_ctrl[0]);
    chk("R3 ale", nf_ale, m_ctrl[1]);
    chk("R3 ce_n", nf_ce_n, !m_ctrl[4]);
    chk("R3 wp", nf_wp, m_ctrl[7]);
    chk("R4 ecc_en", ecc_en, m_ctrl[6:5] == 2'b01);
    chk("R4 ecc_rd", ecc_rd, m_ctrl[6:5] == 2'b10);
    chk("R8 irq", sub_irq, m_irq());
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic pulse;
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    #1;
    chk("R1 io_wr", nf_io_wr, a < 8'h04);
    if (a < 8'h04) chk("R1 io_out", nf_io_out, d);
    pulse = (a == 8'h04) && d[5];
    @(posedge clk); #1;
    reg_wr = 0;
    case (a)
      8'h04: m_ctrl = d;
      8'h06: m_evt = d;
      8'h07: m_ena = d;
      default: if (a < 8'h04) m_evt[0] = 1'b1;
    endcase
    chk("R4 ecc_rst", ecc_rst, pulse);
    check_pins();
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    reg_rd = 1; reg_addr = a; nf_io_in = 8'($urandom);
    #1;
    chk(a < 8'h04 ? "R2 data" : (a == 8'h05 ? "R5 stat" : (a < 8'h08 ? "R6 R3 reg" : "R10 unmapped")),
        reg_rdata, m_read(a, nf_io_in));
    chk("R2 io_rd", nf_io_rd, a < 8'h04);
    @(posedge clk); #1;
    reg_rd = 0;
    chk("R4 no pulse", ecc_rst, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    // R9 reset state
    @(negedge clk);
    check_pins();
    chk("R9 ecc_rst", ecc_rst, 0);
    rd(8'h04); rd(8'h06); rd(8'h07);
    // directed
    wr(8'h04, 8'h13);             // R3 cle/ale, ce asserted
    wr(8'h04, 8'h30);             // R4 field 01
    wr(8'h04, 8'h60);             // R4 field 11
    wr(8'h04, 8'h40);             // R4 field 10, no pulse
    wr(8'h04, 8'h00);             // R4 field 00
    rd(8'h05);                    // R5
    wr(8'h07, 8'h81); wr(8'h03, 8'hA5); // R7 R8
    wr(8'h06, 8'h00);
    wr(8'h07, 8'h01); wr(8'h00, 8'h11); // R8 master off
    wr(8'h07, 8'h80); wr(8'h06, 8'h80); // R8 only master bit
    wr(8'h06, 8'h42); wr(8'h02, 8'h00); rd(8'h06); // R7 keeps other bits
    wr(8'h08, 8'hFF); wr(8'hFF, 8'hFF); rd(8'h08); rd(8'hC4); // R10
    rd(8'h04); rd(8'h07);
    // random
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8);
      if ($urandom % 2) wr(a, 8'($urandom)); else rd(a);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule